// File: doc/BRIEF.md
# Sixteen-Way Branch Condition Evaluator

This block decides whether a conditional branch is taken. In the cycle it is started, it samples an operand byte fetched from the chosen location, the carry and overflow flags, the interrupt-enable state, and a 4-bit selector. That selector occupies the nibble of the register byte that would otherwise name a source register. Only one operand takes part, and nothing is written back.

The selector picks one of sixteen tests. Zero, sign, all-ones and low-bit parity are derived from the operand byte. Carry and overflow come from the flag inputs. Interrupt enable comes from its own input. The last pair of codes is fixed: always taken and never taken.

Codes come in pairs. An even code tests a condition, and the odd code above it tests the opposite. The decision is registered and is flagged by a one-cycle valid pulse on the clock edge after the start strobe.

Top module: `brc_eval`

## Requirements
- R1: While rst_ni is low, and after it is released until the first start, valid_o and taken_o are 0.
- R2: valid_o is 1 in exactly the cycle after a cycle in which start_i was sampled high, and 0 in every other cycle.
- R3: taken_o changes only on a clock edge where start_i is high, and holds its value otherwise, whatever the other inputs do.
- R4: Selector 0 is taken when the sampled operand equals 0x00, and selector 1 when it does not.
- R5: Selector 2 is taken when operand bit 7 is 1, and selector 3 when it is 0.
- R6: Selector 4 is taken when carry_i is 1, and selector 5 when carry_i is 0.
- R7: Selector 6 is taken when ovf_i is 1, and selector 7 when ovf_i is 0.
- R8: Selector 8 is taken when the operand equals 0xFF, and selector 9 when it does not.
- R9: Selector 10 (odd) is taken when operand bit 0 is 1, and selector 11 (even) when it is 0.
- R10: Selector 12 is taken when irq_en_i is 1, and selector 13 when irq_en_i is 0.
- R11: Selector 14 is always taken and selector 15 is never taken.
- R12: For identical inputs, every odd selector 2k+1 yields the inverse of selector 2k.
- R13: The decision uses only the inputs sampled at the start edge. Input changes in the following cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate strobe |
| sel_i | input | 4 | Condition selector |
| operand_i | input | DATA_W | Operand byte under test |
| carry_i | input | 1 | Carry flag |
| ovf_i | input | 1 | Overflow flag |
| irq_en_i | input | 1 | Interrupt-enable state |
| valid_o | output | 1 | Decision-ready pulse |
| taken_o | output | 1 | Registered branch decision |

## Verification
The bench builds the block with its default 8-bit operand width. At that width, all 256 operand values against all 16 selectors form a small exhaustive space, so the 0x00, 0x7F, 0x80 and 0xFF boundaries are covered by construction rather than by chance. The flag-based selectors are applied under all eight carry, overflow and interrupt-enable combinations. The bench scrambles the inputs in the cycle after each start, which shows that the decision stays latched.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    COND_ZERO    = 4'd0,
    COND_NZERO   = 4'd1,
    COND_NEG     = 4'd2,
    COND_POS     = 4'd3,
    COND_CARRY   = 4'd4,
    COND_NCARRY  = 4'd5,
    COND_OVF     = 4'd6,
    COND_NOVF    = 4'd7,
    COND_ONES    = 4'd8,
    COND_NONES   = 4'd9,
    COND_ODD     = 4'd10,
    COND_EVEN    = 4'd11,
    COND_IEN     = 4'd12,
    COND_IDIS    = 4'd13,
    COND_ALWAYS  = 4'd14,
    COND_NEVER   = 4'd15
  } cond_e;

  // one base predicate per selector pair
  localparam int unsigned NUM_PRED = 1 << (SEL_W - 1);
  localparam int unsigned P_ZERO   = 0;
  localparam int unsigned P_NEG    = 1;
  localparam int unsigned P_CARRY  = 2;
  localparam int unsigned P_OVF    = 3;
  localparam int unsigned P_ONES   = 4;
  localparam int unsigned P_ODD    = 5;
  localparam int unsigned P_IEN    = 6;
  localparam int unsigned P_TRUE   = 7;
endpackage

// File: rtl/brc_operand_tests.sv
module brc_operand_tests #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ones_o,
  output logic              odd_o
);
  assign zero_o = ~|operand_i;
  assign ones_o = &operand_i;
  assign neg_o  = operand_i[DATA_W-1];
  assign odd_o  = operand_i[0];

  // all-ones implies sign and odd set and excludes zero (R8, R5, R9)
  always_comb begin
    a_r8_ones_consistent: assert (!ones_o || (neg_o && odd_o && !zero_o));
  end
endmodule

// File: rtl/brc_cond_mux.sv
module brc_cond_mux
  import brc_pkg::*;
(
  input  logic                zero_i,
  input  logic                neg_i,
  input  logic                ones_i,
  input  logic                odd_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  input  logic                irq_en_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                hit_o
);
  logic [NUM_PRED-1:0] pred;
  logic [SEL_W-2:0]    pair;

  assign pred[P_ZERO]  = zero_i;
  assign pred[P_NEG]   = neg_i;
  assign pred[P_CARRY] = carry_i;
  assign pred[P_OVF]   = ovf_i;
  assign pred[P_ONES]  = ones_i;
  assign pred[P_ODD]   = odd_i;
  assign pred[P_IEN]   = irq_en_i;
  assign pred[P_TRUE]  = 1'b1;

  assign pair = sel_i[SEL_W-1:1];

  // low selector bit inverts the sense of the pair
  assign hit_o = pred[pair] ^ sel_i[0];

  always_comb begin
    a_r11_fixed_codes: assert (!(sel_i == COND_ALWAYS) || hit_o);
  end
endmodule

// File: rtl/brc_eval.sv
module brc_eval
  import brc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        sel_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              irq_en_i,
  output logic              valid_o,
  output logic              taken_o
);
  logic zero, neg, ones, odd, hit;
  logic valid_q, taken_q;

  brc_operand_tests #(.DATA_W(DATA_W)) u_optest (
    .operand_i (operand_i),
    .zero_o    (zero),
    .neg_o     (neg),
    .ones_o    (ones),
    .odd_o     (odd)
  );

  brc_cond_mux u_mux (
    .zero_i   (zero),
    .neg_i    (neg),
    .ones_i   (ones),
    .odd_i    (odd),
    .carry_i  (carry_i),
    .ovf_i    (ovf_i),
    .irq_en_i (irq_en_i),
    .sel_i    (sel_i),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) taken_q <= hit;
    end
  end

  assign valid_o = valid_q;
  assign taken_o = taken_q;

  a_r2_valid_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(taken_o));
  a_r11_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_i == COND_ALWAYS) |=> taken_o);
  a_r11_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_i == COND_NEVER) |=> !taken_o);
  a_r6_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_i == COND_CARRY) |=> (taken_o == $past(carry_i)));
  a_r4_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_i == COND_ZERO) |=> (taken_o == ($past(operand_i) == '0)));
endmodule

// File: tb/brc_eval_bench.sv
module brc_eval_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] sel_i = '0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0, ovf_i = 1'b0, irq_en_i = 1'b0;
  logic       valid_o, taken_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5ns clk_i = ~clk_i;

  brc_eval u_brc_eval (
    .clk_i, .rst_ni, .start_i, .sel_i, .operand_i,
    .carry_i, .ovf_i, .irq_en_i, .valid_o, .taken_o
  );

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (sel=%0d op=%02h c=%b v=%b ie=%b)",
               req, act, exp, sel_i, operand_i, carry_i, ovf_i, irq_en_i);
    end
  endtask

  // expected decision straight from the requirement table
  function automatic logic model(logic [3:0] s, logic [7:0] op, logic c, logic v, logic ie);
    case (s)
      4'd0:  return op == 8'h00;   // R4
      4'd1:  return op != 8'h00;
      4'd2:  return op[7];         // R5
      4'd3:  return !op[7];
      4'd4:  return c;             // R6
      4'd5:  return !c;
      4'd6:  return v;             // R7
      4'd7:  return !v;
      4'd8:  return op == 8'hFF;   // R8
      4'd9:  return op != 8'hFF;
      4'd10: return op[0];         // R9
      4'd11: return !op[0];
      4'd12: return ie;            // R10
      4'd13: return !ie;
      4'd14: return 1'b1;          // R11
      default: return 1'b0;
    endcase
  endfunction

  // start, then scramble inputs; sample after the registering edge (R13)
  task automatic apply(logic [3:0] s, logic [7:0] op, logic c, logic v, logic ie,
                       output logic got_v, output logic got_t);
    @(negedge clk_i);
    sel_i = s; operand_i = op; carry_i = c; ovf_i = v; irq_en_i = ie; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    operand_i = ~op; carry_i = ~c; ovf_i = ~v; irq_en_i = ~ie; sel_i = s ^ 4'd1;
    got_v = valid_o; got_t = taken_o;
  endtask

  task automatic t_reset();
    #1ns;
    check("R1 valid in reset", valid_o, 1'b0);
    check("R1 taken in reset", taken_o, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after release", valid_o, 1'b0);
    check("R1 taken after release", taken_o, 1'b0);
  endtask

  task automatic t_operand_sweep();
    logic gv, gt, prev;
    for (int op = 0; op < 256; op++) begin
      for (int s = 0; s < 16; s++) begin
        logic c, v, ie;
        c = op[1]; v = op[2]; ie = op[3];
        apply(4'(s), 8'(op), c, v, ie, gv, gt);
        check("R2 valid pulse", gv, 1'b1);
        check("R4-R11 R13 decision", gt, model(4'(s), 8'(op), c, v, ie));
        if (s[0]) check("R12 pair inverse", gt, !prev);
        prev = gt;
      end
    end
  endtask

  task automatic t_flags();
    logic gv, gt;
    for (int f = 0; f < 8; f++) begin
      for (int s = 4; s < 14; s++) begin
        if (s == 8) s = 12;
        apply(4'(s), 8'h3C, f[0], f[1], f[2], gv, gt);
        check("R6 R7 R10 flag test", gt, model(4'(s), 8'h3C, f[0], f[1], f[2]));
      end
    end
  endtask

  task automatic t_fixed();
    logic gv, gt;
    apply(4'd14, 8'h00, 1'b0, 1'b0, 1'b0, gv, gt);
    check("R11 always", gt, 1'b1);
    apply(4'd15, 8'hFF, 1'b1, 1'b1, 1'b1, gv, gt);
    check("R11 never", gt, 1'b0);
  endtask

  task automatic t_hold();
    logic gv, gt;
    apply(4'd14, 8'h00, 1'b0, 1'b0, 1'b0, gv, gt);
    for (int i = 0; i < 4; i++) begin
      sel_i = 4'd15; operand_i = 8'(i * 37);
      @(negedge clk_i);
      check("R2 valid low when idle", valid_o, 1'b0);
      check("R3 taken held", taken_o, 1'b1);
    end
    apply(4'd15, 8'h00, 1'b0, 1'b0, 1'b0, gv, gt);
    sel_i = 4'd14;
    @(negedge clk_i);
    check("R3 taken held low", taken_o, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #3ms;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fixed();
    t_hold();
    t_flags();
    t_operand_sweep();
    finish_run();
  end
endmodule